// File: doc/BRIEF.md
# Predicated Vector Load Address Sequencer

This block walks through the elements of a scalar load instruction that has been widened to vector form. It accepts two addressing forms. In the indexed form the address is a base register element plus an index register element. In the immediate form it is a base register element plus a constant offset; an offset equal to the access size gives unit stride. On each start it latches one job description: the vector length, a source mask, a destination mask, vector/scalar flags for the destination, base and index operands, the access size and the register numbers.

The block keeps three independent element positions, one each for base, index and destination. Before each element it moves every vector operand past positions whose mask bit is clear. It then reads the operands through two combinational register-file read ports, forms the address and issues one memory read. It waits for the response and writes the returned data to the destination register. In update mode it also writes the address to a separate update register at the base position when the request is accepted. The sequence ends early on a scalar destination or on scalar sources, and a one-cycle done pulse marks the end.

The control is a five-state machine:
- IDLE waits for start, and IDLE→SKIP latches the job.
- SKIP advances masked positions. It takes SKIP→DONE when any position has run out, SKIP→ISSUE when no position is blocked, and otherwise stays in SKIP.
- ISSUE holds the request. It takes ISSUE→WAIT on acceptance.
- WAIT takes WAIT→DONE on a response for the last element and WAIT→SKIP on any other response.
- DONE always takes DONE→IDLE.

Top module: `vld_seq`

## Requirements
- R1: Once reset is released, and until a start is accepted, busy, done, mem_req_valid, dst_we and upd_we are all low.
- R2: mem_req_bytes gives the access size from size_code: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8.
- R3: When indexed is 1, the request address is the value of register (base_reg + i) plus the value of register (idx_reg + k). Register numbers wrap modulo 2^RW.
- R4: When indexed is 0, the request address is the value of register (base_reg + i) plus imm. The index operand then counts as scalar and plays no part.
- R5: Before each element, every vector operand whose mask bit at its current position is clear steps forward. Base and index use src_pred, and the destination uses dst_pred. A scalar operand never steps.
- R6: After each processed element, every vector operand position increments by one. Scalar positions stay at zero.
- R7: With dst_vec low, or with both source operands scalar, exactly one element is processed, provided one is reachable.
- R8: When any position reaches the vector length, the sequence ends with no further request. A vector length of 0 issues nothing, and lengths above VLEN_MAX are treated as VLEN_MAX.
- R9: In update mode, upd_we pulses in the cycle the request is accepted, with upd_waddr = upd_reg + i and upd_wdata equal to the request address.
- R10: Each request carries mem_req_tag = dst_reg + j. Its response produces dst_we with dst_waddr equal to that tag and dst_wdata equal to mem_rsp_data.
- R11: A request stays valid with a stable address until accepted. Only one request is outstanding at a time, and no new request appears before the response returns.
- R12: done is high for exactly one cycle per job. busy is high from the cycle after start until done. A start seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; sampled only when idle |
| vl | input | CW | Vector length |
| src_pred | input | VLEN_MAX | Source element mask |
| dst_pred | input | VLEN_MAX | Destination element mask |
| dst_vec | input | 1 | Destination is a vector |
| base_vec | input | 1 | Base operand is a vector |
| idx_vec | input | 1 | Index operand is a vector |
| indexed | input | 1 | 1 = base+index, 0 = base+immediate |
| update_en | input | 1 | Write address to update register |
| size_code | input | 2 | Access size code |
| imm | input | AW | Immediate offset |
| base_reg | input | RW | Base register number |
| idx_reg | input | RW | Index register number |
| dst_reg | input | RW | Destination register number |
| upd_reg | input | RW | Update register number |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| rf_ra_addr | output | RW | Base operand read address |
| rf_ra_data | input | AW | Base operand read data |
| rf_rb_addr | output | RW | Index operand read address |
| rf_rb_data | input | AW | Index operand read data |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | AW | Effective address |
| mem_req_bytes | output | 4 | Access size in bytes |
| mem_req_tag | output | RW | Destination register tag |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | AW | Read response data |
| dst_we | output | 1 | Destination write enable |
| dst_waddr | output | RW | Destination register number |
| dst_wdata | output | AW | Destination write data |
| upd_we | output | 1 | Update write enable |
| upd_waddr | output | RW | Update register number |
| upd_wdata | output | AW | Update write data |

## Verification
A position that steps wrongly or fails to reset between jobs shows up at the first request after the error. The address then comes from a different register, or the tag or update register number shifts by one, so a per-element comparison against a bench model catches it within one element. A wrong termination decision changes the number of requests and moves the done pulse, and this becomes visible when the job ends. Handshake faults, such as an address that changes while stalled or a write while a request is pending, are flagged in the cycle they happen.

// File: rtl/vld_seq_pkg.sv
package vld_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    localparam int unsigned NUM_POS  = 3;
    localparam int unsigned POS_BASE = 0;
    localparam int unsigned POS_IDX  = 1;
    localparam int unsigned POS_DST  = 2;
endpackage

// File: rtl/vld_seq_pos.sv
module vld_seq_pos #(
    parameter int unsigned N  = 8,
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          skip_en,
    input  logic          adv_en,
    input  logic          is_vec,
    input  logic [N-1:0]  mask,
    input  logic [CW-1:0] vl,
    output logic [CW-1:0] pos,
    output logic          blocked,
    output logic          spent
);
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    logic [CW-1:0] pos_q;
    logic          bit_on;

    always_comb begin
        spent   = (pos_q >= vl);
        bit_on  = spent ? 1'b1 : mask[pos_q[IW-1:0]];
        blocked = is_vec && !spent && !bit_on;
        pos     = pos_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (clear) begin
            pos_q <= '0;
        end else if ((skip_en && blocked) || (adv_en && is_vec)) begin
            pos_q <= pos_q + 1'b1;
        end
    end
endmodule

// File: rtl/vld_seq_agen.sv
module vld_seq_agen #(
    parameter int unsigned AW = 64
) (
    input  logic          indexed,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] idx_val,
    input  logic [AW-1:0] imm,
    output logic [AW-1:0] ea
);
    logic [AW-1:0] offset;

    always_comb begin
        offset = indexed ? idx_val : imm;
        ea     = base_val + offset;
    end
endmodule

// File: rtl/vld_seq.sv
module vld_seq
    import vld_seq_pkg::*;
#(
    parameter int unsigned VLEN_MAX = 8,
    parameter int unsigned AW       = 64,
    parameter int unsigned RW       = 5,
    parameter int unsigned CW       = $clog2(VLEN_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CW-1:0]       vl,
    input  logic [VLEN_MAX-1:0] src_pred,
    input  logic [VLEN_MAX-1:0] dst_pred,
    input  logic                dst_vec,
    input  logic                base_vec,
    input  logic                idx_vec,
    input  logic                indexed,
    input  logic                update_en,
    input  logic [1:0]          size_code,
    input  logic [AW-1:0]       imm,
    input  logic [RW-1:0]       base_reg,
    input  logic [RW-1:0]       idx_reg,
    input  logic [RW-1:0]       dst_reg,
    input  logic [RW-1:0]       upd_reg,
    output logic                busy,
    output logic                done,
    output logic [RW-1:0]       rf_ra_addr,
    input  logic [AW-1:0]       rf_ra_data,
    output logic [RW-1:0]       rf_rb_addr,
    input  logic [AW-1:0]       rf_rb_data,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [AW-1:0]       mem_req_addr,
    output logic [3:0]          mem_req_bytes,
    output logic [RW-1:0]       mem_req_tag,
    input  logic                mem_rsp_valid,
    input  logic [AW-1:0]       mem_rsp_data,
    output logic                dst_we,
    output logic [RW-1:0]       dst_waddr,
    output logic [AW-1:0]       dst_wdata,
    output logic                upd_we,
    output logic [RW-1:0]       upd_waddr,
    output logic [AW-1:0]       upd_wdata
);
    localparam logic [CW-1:0] VL_CAP = CW'(VLEN_MAX);

    seq_state_e state_q, state_d;

    logic [CW-1:0]       vl_q;
    logic [VLEN_MAX-1:0] spred_q, dpred_q;
    logic                dvec_q, bvec_q, xvec_q, indexed_q, upd_q;
    logic [1:0]          size_q;
    logic [AW-1:0]       imm_q;
    logic [RW-1:0]       breg_q, xreg_q, dreg_q, ureg_q;

    logic [NUM_POS-1:0]  pos_vec;
    logic [VLEN_MAX-1:0] pos_mask [NUM_POS];
    logic [CW-1:0]       pos_val  [NUM_POS];
    logic [NUM_POS-1:0]  pos_blk;
    logic [NUM_POS-1:0]  pos_spent;

    logic pos_clear, pos_skip, pos_adv;
    logic any_spent, any_blocked, last_elem, accept;
    logic [AW-1:0] ea;

    // Job capture on an accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q      <= '0;
            spred_q   <= '0;
            dpred_q   <= '0;
            dvec_q    <= 1'b0;
            bvec_q    <= 1'b0;
            xvec_q    <= 1'b0;
            indexed_q <= 1'b0;
            upd_q     <= 1'b0;
            size_q    <= '0;
            imm_q     <= '0;
            breg_q    <= '0;
            xreg_q    <= '0;
            dreg_q    <= '0;
            ureg_q    <= '0;
        end else if (state_q == ST_IDLE && start) begin
            vl_q      <= (vl > VL_CAP) ? VL_CAP : vl;
            spred_q   <= src_pred;
            dpred_q   <= dst_pred;
            dvec_q    <= dst_vec;
            bvec_q    <= base_vec;
            xvec_q    <= indexed && idx_vec;
            indexed_q <= indexed;
            upd_q     <= update_en;
            size_q    <= size_code;
            imm_q     <= imm;
            breg_q    <= base_reg;
            xreg_q    <= idx_reg;
            dreg_q    <= dst_reg;
            ureg_q    <= upd_reg;
        end
    end

    // Element positions: base, index, destination
    always_comb begin
        pos_vec[POS_BASE]  = bvec_q;
        pos_vec[POS_IDX]   = xvec_q;
        pos_vec[POS_DST]   = dvec_q;
        pos_mask[POS_BASE] = spred_q;
        pos_mask[POS_IDX]  = spred_q;
        pos_mask[POS_DST]  = dpred_q;
    end

    for (genvar g = 0; g < NUM_POS; g++) begin : g_pos
        vld_seq_pos #(.N(VLEN_MAX), .CW(CW)) u_pos (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (pos_clear),
            .skip_en (pos_skip),
            .adv_en  (pos_adv),
            .is_vec  (pos_vec[g]),
            .mask    (pos_mask[g]),
            .vl      (vl_q),
            .pos     (pos_val[g]),
            .blocked (pos_blk[g]),
            .spent   (pos_spent[g])
        );
    end

    vld_seq_agen #(.AW(AW)) u_agen (
        .indexed  (indexed_q),
        .base_val (rf_ra_data),
        .idx_val  (rf_rb_data),
        .imm      (imm_q),
        .ea       (ea)
    );

    always_comb begin
        any_spent   = |pos_spent;
        any_blocked = |pos_blk;
        last_elem   = !dvec_q || (!bvec_q && !xvec_q);
        accept      = (state_q == ST_ISSUE) && mem_req_ready;
        pos_clear   = (state_q == ST_IDLE);
        pos_skip    = (state_q == ST_SKIP) && !any_spent;
        pos_adv     = (state_q == ST_WAIT) && mem_rsp_valid && !last_elem;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SKIP;
            ST_SKIP: begin
                if (any_spent)         state_d = ST_DONE;
                else if (!any_blocked) state_d = ST_ISSUE;
            end
            ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) state_d = last_elem ? ST_DONE : ST_SKIP;
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        done          = (state_q == ST_DONE);
        rf_ra_addr    = breg_q + RW'(pos_val[POS_BASE]);
        rf_rb_addr    = xreg_q + RW'(pos_val[POS_IDX]);
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_addr  = ea;
        mem_req_bytes = 4'd1 << size_q;
        mem_req_tag   = dreg_q + RW'(pos_val[POS_DST]);
        dst_we        = (state_q == ST_WAIT) && mem_rsp_valid;
        dst_waddr     = dreg_q + RW'(pos_val[POS_DST]);
        dst_wdata     = mem_rsp_data;
        upd_we        = accept && upd_q;
        upd_waddr     = ureg_q + RW'(pos_val[POS_BASE]);
        upd_wdata     = ea;
    end
endmodule

// File: rtl/vld_seq_chk.sv
module vld_seq_chk #(
    parameter int unsigned AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr,
    input logic          dst_we,
    input logic          upd_we,
    input logic [AW-1:0] upd_wdata
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !dst_we && !upd_we && !done)); // R1

    AST_UPD_AT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_we |-> (mem_req_valid && mem_req_ready && upd_wdata == mem_req_addr)); // R9

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !dst_we); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

    AST_DONE_ENDS_JOB: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R12
endmodule

bind vld_seq vld_seq_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .done          (done),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .dst_we        (dst_we),
    .upd_we        (upd_we),
    .upd_wdata     (upd_wdata)
);

// File: tb/vld_seq_test.sv
`timescale 1ns/1ps
module vld_seq_test;
    localparam int N  = 8;
    localparam int AW = 64;
    localparam int RW = 5;
    localparam int CW = 4;

    typedef struct {
        int          vl;
        logic [N-1:0] spred, dpred;
        bit          dvec, bvec, xvec, indexed, upd;
        logic [1:0]  size;
        logic [AW-1:0] imm;
        logic [RW-1:0] breg, xreg, dreg, ureg;
    } job_t;

    logic clk = 0, rst_n = 0;
    always #5 clk = ~clk;

    logic start = 0;
    logic [CW-1:0] vl = 0;
    logic [N-1:0] src_pred = 0, dst_pred = 0;
    logic dst_vec = 0, base_vec = 0, idx_vec = 0, indexed = 0, update_en = 0;
    logic [1:0] size_code = 0;
    logic [AW-1:0] imm = 0;
    logic [RW-1:0] base_reg = 0, idx_reg = 0, dst_reg = 0, upd_reg = 0;
    logic busy, done;
    logic [RW-1:0] rf_ra_addr, rf_rb_addr;
    logic [AW-1:0] rf_ra_data, rf_rb_data;
    logic mem_req_valid, mem_req_ready;
    logic [AW-1:0] mem_req_addr;
    logic [3:0] mem_req_bytes;
    logic [RW-1:0] mem_req_tag;
    logic mem_rsp_valid;
    logic [AW-1:0] mem_rsp_data;
    logic dst_we, upd_we;
    logic [RW-1:0] dst_waddr, upd_waddr;
    logic [AW-1:0] dst_wdata, upd_wdata;

    function automatic logic [AW-1:0] rfval(input logic [RW-1:0] r);
        return {32'h0, 24'h1000, 3'b0, r} * 64'd97 + 64'h40;
    endfunction
    function automatic logic [AW-1:0] mdata(input logic [AW-1:0] a);
        return a ^ 64'h5A5A_0000_C3C3_1234;
    endfunction

    assign rf_ra_data = rfval(rf_ra_addr);
    assign rf_rb_data = rfval(rf_rb_addr);

    vld_seq #(.VLEN_MAX(N), .AW(AW), .RW(RW)) uut (.*);

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string rq, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Observed traffic
    logic [AW-1:0] got_addr [16], got_udata [16], got_wdata [16];
    logic [RW-1:0] got_tag [16], got_uaddr [16], got_waddr [16];
    logic [3:0]    got_bytes [16];
    int n_req = 0, n_upd = 0, n_wr = 0, n_done = 0;
    bit acc_flag = 0;
    logic [AW-1:0] last_addr = 0;

    always @(negedge clk) if (rst_n) begin
        if (mem_req_valid && mem_req_ready) begin
            if (n_req < 16) begin
                got_addr[n_req] = mem_req_addr;
                got_tag[n_req] = mem_req_tag;
                got_bytes[n_req] = mem_req_bytes;
            end
            n_req++;
            acc_flag = 1;
            last_addr = mem_req_addr;
        end
        if (upd_we) begin
            if (n_upd < 16) begin
                got_uaddr[n_upd] = upd_waddr;
                got_udata[n_upd] = upd_wdata;
            end
            n_upd++;
        end
        if (dst_we) begin
            if (n_wr < 16) begin
                got_waddr[n_wr] = dst_waddr;
                got_wdata[n_wr] = dst_wdata;
            end
            n_wr++;
        end
        if (done) n_done++;
    end

    // Memory responder
    initial begin
        int unsigned dly;
        bit pend;
        dly = 0;
        pend = 0;
        mem_req_ready = 0;
        mem_rsp_valid = 0;
        mem_rsp_data = 0;
        forever begin
            @(posedge clk); #1;
            mem_rsp_valid = 0;
            if (acc_flag) begin
                acc_flag = 0;
                pend = 1;
                dly = $urandom % 3;
            end
            if (pend) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_data = mdata(last_addr);
                    pend = 0;
                end else dly--;
            end
            mem_req_ready = ($urandom % 4) != 0;
        end
    end

    // Reference model
    logic [AW-1:0] exp_addr [16], exp_wdata [16];
    logic [RW-1:0] exp_tag [16], exp_uaddr [16];
    int exp_n;

    task automatic model(input job_t c);
        int i, j, k, lim;
        bit bv, xv, dv;
        logic [AW-1:0] ea;
        lim = (c.vl > N) ? N : c.vl;
        bv = c.bvec;
        xv = c.indexed && c.xvec;
        dv = c.dvec;
        i = 0; j = 0; k = 0; exp_n = 0;
        forever begin
            while (bv && i < lim && !c.spred[i]) i++;
            while (xv && k < lim && !c.spred[k]) k++;
            while (dv && j < lim && !c.dpred[j]) j++;
            if (i >= lim || j >= lim || k >= lim) break;
            if (c.indexed) ea = rfval(RW'(c.breg + i)) + rfval(RW'(c.xreg + k));
            else           ea = rfval(RW'(c.breg + i)) + c.imm;
            exp_addr[exp_n]  = ea;
            exp_tag[exp_n]   = RW'(c.dreg + j);
            exp_uaddr[exp_n] = RW'(c.ureg + i);
            exp_wdata[exp_n] = mdata(ea);
            exp_n++;
            if (!dv || (!bv && !xv)) break;
            if (bv) i++;
            if (xv) k++;
            if (dv) j++;
        end
    endtask

    task automatic drive(input job_t c);
        vl = CW'(c.vl); src_pred = c.spred; dst_pred = c.dpred;
        dst_vec = c.dvec; base_vec = c.bvec; idx_vec = c.xvec;
        indexed = c.indexed; update_en = c.upd; size_code = c.size;
        imm = c.imm; base_reg = c.breg; idx_reg = c.xreg;
        dst_reg = c.dreg; upd_reg = c.ureg;
    endtask

    task automatic run_job(input job_t c, input bit poke, input job_t other);
        int cyc;
        n_req = 0; n_upd = 0; n_wr = 0; n_done = 0;
        model(c);
        @(posedge clk); #1;
        drive(c);
        start = 1;
        @(posedge clk); #1;
        start = 0;
        @(negedge clk);
        chk(busy === 1'b1, "R12 busy after start", AW'(busy), 1);
        cyc = 0;
        while (n_done == 0 && cyc < 2000) begin
            if (poke && cyc == 3) begin
                @(posedge clk); #1;
                drive(other);
                start = 1;
                @(posedge clk); #1;
                start = 0;
            end
            @(negedge clk);
            cyc++;
        end
        chk(cyc < 2000, "R12 watchdog", AW'(cyc), 0);
        @(negedge clk);
        chk(busy === 1'b0, "R12 idle after done", AW'(busy), 0);
        chk(n_done == 1, "R12 done count", AW'(n_done), 1);
        chk(n_req == exp_n, "R5 R6 R7 R8 request count", AW'(n_req), AW'(exp_n));
        chk(n_wr == n_req, "R11 response per request", AW'(n_wr), AW'(n_req));
        chk(n_upd == (c.upd ? exp_n : 0), "R9 update count", AW'(n_upd), AW'(c.upd ? exp_n : 0));
        for (int e = 0; e < exp_n && e < n_req && e < 16; e++) begin
            chk(got_addr[e] == exp_addr[e], c.indexed ? "R3 address" : "R4 address",
                got_addr[e], exp_addr[e]);
            chk(got_bytes[e] == (4'd1 << c.size), "R2 bytes", AW'(got_bytes[e]), AW'(4'd1 << c.size));
            chk(got_tag[e] == exp_tag[e], "R10 tag", AW'(got_tag[e]), AW'(exp_tag[e]));
            if (e < n_wr) begin
                chk(got_waddr[e] == exp_tag[e], "R10 dst addr", AW'(got_waddr[e]), AW'(exp_tag[e]));
                chk(got_wdata[e] == exp_wdata[e], "R10 dst data", got_wdata[e], exp_wdata[e]);
            end
            if (c.upd && e < n_upd) begin
                chk(got_uaddr[e] == exp_uaddr[e], "R9 update addr", AW'(got_uaddr[e]), AW'(exp_uaddr[e]));
                chk(got_udata[e] == exp_addr[e], "R9 update data", got_udata[e], exp_addr[e]);
            end
        end
    endtask

    function automatic job_t base_job();
        job_t c;
        c.vl = 8; c.spred = '1; c.dpred = '1;
        c.dvec = 1; c.bvec = 1; c.xvec = 1; c.indexed = 1; c.upd = 0;
        c.size = 2'd3; c.imm = 64'd8;
        c.breg = 5'd2; c.xreg = 5'd12; c.dreg = 5'd20; c.ureg = 5'd26;
        return c;
    endfunction

    initial begin
        job_t c, o;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy === 0 && done === 0 && mem_req_valid === 0 && dst_we === 0 && upd_we === 0,
            "R1 reset state", {59'd0, busy, done, mem_req_valid, dst_we, upd_we}, 0);
        #1 rst_n = 1;
        @(negedge clk);
        chk(busy === 0 && mem_req_valid === 0, "R1 idle after reset", AW'(busy), 0);

        // Directed: full indexed vector, with update
        c = base_job(); c.upd = 1;
        run_job(c, 0, c);
        // R8: zero length
        c = base_job(); c.vl = 0;
        run_job(c, 0, c);
        // R8: masks empty, vector base skips to the end
        c = base_job(); c.spred = '0;
        run_job(c, 0, c);
        // R7: scalar destination
        c = base_job(); c.dvec = 0; c.spred = 8'b1010_0100;
        run_job(c, 0, c);
        // R7: both sources scalar
        c = base_job(); c.bvec = 0; c.xvec = 0; c.dpred = 8'b0011_0000;
        run_job(c, 0, c);
        // R4: immediate unit stride, index flag ignored, size 4
        c = base_job(); c.indexed = 0; c.size = 2'd2; c.imm = 64'd4; c.upd = 1;
        c.spred = 8'b1101_0110; c.dpred = 8'b0111_1011;
        run_job(c, 0, c);
        // R3: register number wrap, vl above capacity, scalar index
        c = base_job(); c.breg = 5'd30; c.dreg = 5'd29; c.xvec = 0; c.vl = 15; c.upd = 1; c.ureg = 5'd31;
        run_job(c, 0, c);
        // R12: start while busy is ignored
        c = base_job(); c.dpred = 8'b1110_1111;
        o = base_job(); o.vl = 1; o.breg = 5'd7; o.indexed = 0; o.imm = 64'h99;
        run_job(c, 1, o);

        // Constrained random jobs
        for (int t = 0; t < 40; t++) begin
            c.vl = $urandom % 10;
            c.spred = N'($urandom); c.dpred = N'($urandom);
            c.dvec = ($urandom % 4) != 0; c.bvec = ($urandom % 4) != 0;
            c.xvec = $urandom % 2; c.indexed = $urandom % 2; c.upd = $urandom % 2;
            c.size = 2'($urandom); c.imm = {32'h0, 24'h0, 8'($urandom)};
            c.breg = RW'($urandom); c.xreg = RW'($urandom);
            c.dreg = RW'($urandom); c.ureg = RW'($urandom);
            run_job(c, 0, c);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule